// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File with Interrupt Combining

This block holds the host-visible register set of a two-channel bus-master DMA controller for ATA drives. It also holds the interrupt logic for both channels. A 16-byte I/O window is split into two 8-byte groups, one per channel. Each group carries a command byte, a view of a mode byte shared by both channels, a status byte, a timing byte for that channel and a 32-bit descriptor-table pointer. The command bits, the timing bytes and the pointers are driven out to the data engine. The engine returns an active level, an error strobe and an interrupt strobe for each channel.

Each drive channel supplies an interrupt-request level. These levels are sampled into pending flags in the shared mode byte. Each pending flag is gated by a block bit that the host can write. The gated results are ORed into one level-sensitive interrupt output.

Host accesses are 1, 2 or 4 bytes wide. The access address is aligned down to the access size, and the data is right-aligned, with the lowest addressed byte in bits 7:0. Reads are combinational and have no side effects. Writes take effect at the next rising clock edge.

Top module: `ide_bm_regs`

## Requirements
- R1: After reset, every register reads zero. This covers command, mode, status bits 1, 2, 5 and 6, timing and descriptor pointer. The interrupt output is low.
- R2: Channel 0 occupies offsets 0–7 and channel 1 occupies offsets 8–15. Within a group, offset 0 is command, 1 is mode, 2 is status, 3 is timing and 4–7 is the descriptor pointer, least significant byte first.
- R3: Offset 1 and offset 9 always return the same shared mode byte.
- R4: A mode write changes only bit 4 (channel 0 block) and bit 5 (channel 1 block). Bits 0, 1, 6 and 7 read zero.
- R5: Mode bit 2 (channel 0 pending) and bit 3 (channel 1 pending) hold the value the channel request input had at the previous clock edge.
- R6: The interrupt output equals (bit2 AND NOT bit4) OR (bit3 AND NOT bit5) of the registered mode byte. It therefore responds one cycle after a request change or a mode write.
- R7: A status write loads bits 5 and 6 from the written data. Bit 0 always shows the channel's engine-active input and is unaffected by writes. Bits 3, 4 and 7 read zero.
- R8: Status bit 1 is set by the error strobe and status bit 2 by the interrupt strobe. Writing 1 to either bit clears it. A strobe in the same cycle as the clearing write wins, and writing 0 leaves the bit unchanged.
- R9: Each channel has its own timing byte at offset 3 or 11. A write to one leaves the other unchanged.
- R10: The descriptor pointer accepts byte, 16-bit and 32-bit reads and writes, with the address aligned down to the access size.
- R11: Command bit 0 (start) and bit 3 (direction) are writable and are driven to the engine. The other command bits read zero.
- R12: Read lanes above the access size return 0xFF. Size code 3 is reserved: it writes nothing and reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_addr_i | input | 4 | Byte offset in the window |
| host_size_i | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| host_wr_i | input | 1 | Write strobe for this cycle |
| host_wdata_i | input | 32 | Write data, right-aligned |
| host_rdata_o | output | 32 | Read data, right-aligned, combinational |
| chan_irq_i | input | 2 | Drive interrupt request level per channel |
| eng_active_i | input | 2 | Engine active per channel |
| eng_err_i | input | 2 | Engine error strobe per channel |
| eng_int_i | input | 2 | Engine interrupt strobe per channel |
| dma_start_o | output | 2 | Command start bit per channel |
| dma_dir_o | output | 2 | Command direction bit per channel |
| timing_o | output | 16 | Timing byte per channel, channel 0 low |
| desc_addr_o | output | 64 | Descriptor pointer per channel, channel 0 low |
| irq_o | output | 1 | Combined level interrupt |

## Verification
The assertions check several rules on every cycle. The pending flags must track the sampled request inputs. Block bits and status bits 5–6 must load from their writes. Clear-on-one must hold unless a strobe arrives. The untouched timing byte must hold its value. Both channel views of the mode byte must agree. An interrupt must never appear with both channels blocked or with nothing pending. Only the bench scenarios show the rest: byte placement across sizes and misaligned addresses, the 0xFF fill of unused lanes, the read-back of command and timing values, and the interrupt level under changing request and block patterns, all compared against a separate model.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int NUM_CH     = 2;
  localparam int DESC_BYTES = 4;
  localparam int OFF_CMD    = 0;
  localparam int OFF_MODE   = 1;
  localparam int OFF_STAT   = 2;
  localparam int OFF_TIM    = 3;
  localparam int OFF_ADR    = 4;
  localparam int GRP_BYTES  = OFF_ADR + DESC_BYTES;
  localparam int WIN_BYTES  = NUM_CH * GRP_BYTES;
  localparam int WIN_AW     = $clog2(WIN_BYTES);
  localparam int LANES      = DESC_BYTES;

  // command bits
  localparam int CMD_START  = 0;
  localparam int CMD_DIR    = 3;
  // mode bits
  localparam int MODE_PEND_LSB = 2;
  localparam int MODE_BLK_LSB  = 4;
  // status bits
  localparam int ST_ACT      = 0;
  localparam int ST_ERR      = 1;
  localparam int ST_INT      = 2;
  localparam int ST_KEEP_LSB = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/ide_bm_decode.sv
module ide_bm_decode
  import ide_bm_pkg::*;
(
  input  logic [WIN_AW-1:0]               addr_i,
  input  logic [1:0]                      size_i,
  input  logic                            wr_i,
  input  logic [LANES*8-1:0]              wdata_i,
  output logic [WIN_BYTES-1:0]            we_o,
  output logic [WIN_BYTES-1:0][7:0]       wbyte_o,
  output logic [LANES-1:0]                lane_ok_o,
  output logic [LANES-1:0][WIN_AW-1:0]    lane_off_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [WIN_AW-1:0] mask, base;
  logic              legal;

  always_comb begin
    legal = 1'b1;
    case (acc_size_e'(size_i))
      SZ_BYTE: mask = WIN_AW'(0);
      SZ_HALF: mask = WIN_AW'(1);
      SZ_WORD: mask = WIN_AW'(3);
      default: begin
        mask  = WIN_AW'(0);
        legal = 1'b0;
      end
    endcase
    base = addr_i & ~mask;
  end

  for (genvar o = 0; o < WIN_BYTES; o++) begin : g_byte
    localparam logic [WIN_AW-1:0] OFF = WIN_AW'(o);
    logic [1:0]         lane;
    logic [LANES*8-1:0] sh;
    assign lane       = 2'(OFF & mask);
    assign sh         = wdata_i >> {lane, 3'b000};
    assign wbyte_o[o] = sh[7:0];
    assign we_o[o]    = wr_i & legal & ((OFF & ~mask) == base);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_ok_o[j]  = legal && (WIN_AW'(j) <= mask);
    assign lane_off_o[j] = base | WIN_AW'(j);
  end
endmodule

// File: rtl/ide_bm_mode.sv
module ide_bm_mode
  import ide_bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic [7:0]        mode_o,
  output logic              irq_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [NUM_CH-1:0] pend_q, blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      blk_q  <= '0;
    end else begin
      pend_q <= req_i;
      if (we_i) blk_q <= wdata_i[MODE_BLK_LSB +: NUM_CH];
    end
  end

  always_comb begin
    mode_o = '0;
    mode_o[MODE_PEND_LSB +: NUM_CH] = pend_q;
    mode_o[MODE_BLK_LSB  +: NUM_CH] = blk_q;
  end

  assign irq_o = |(pend_q & ~blk_q);

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[7:6], wdata_i[3:0]};

  // R5
  pend_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q == $past(req_i)));
  // R4
  blk_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (blk_q == $past(wdata_i[MODE_BLK_LSB +: NUM_CH])));
  // R6
  irq_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&blk_q) |-> !irq_o);
  // R6
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|pend_q));
endmodule

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_bm_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [GRP_BYTES-1:0]          we_i,
  input  logic [GRP_BYTES-1:0][7:0]     wbyte_i,
  input  logic [7:0]                    mode_i,
  input  logic                          active_i,
  input  logic                          err_i,
  input  logic                          int_i,
  output logic [GRP_BYTES-1:0][7:0]     rbyte_o,
  output logic                          start_o,
  output logic                          dir_o,
  output logic [7:0]                    timing_o,
  output logic [DESC_BYTES*8-1:0]       desc_o
);
  timeunit 1ns; timeprecision 1ps;

  logic                        start_q, dir_q, err_q, int_q;
  logic [1:0]                  keep_q;
  logic [7:0]                  tim_q;
  logic [DESC_BYTES-1:0][7:0]  desc_q;
  logic [7:0]                  st_w, cmd_w;
  logic                        clr_err, clr_int;

  assign st_w    = wbyte_i[OFF_STAT];
  assign cmd_w   = wbyte_i[OFF_CMD];
  assign clr_err = we_i[OFF_STAT] & st_w[ST_ERR];
  assign clr_int = we_i[OFF_STAT] & st_w[ST_INT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      keep_q  <= '0;
      err_q   <= 1'b0;
      int_q   <= 1'b0;
      tim_q   <= '0;
    end else begin
      if (we_i[OFF_CMD]) begin
        start_q <= cmd_w[CMD_START];
        dir_q   <= cmd_w[CMD_DIR];
      end
      if (we_i[OFF_STAT]) keep_q <= st_w[ST_KEEP_LSB +: 2];
      // strobe beats a same-cycle clear
      err_q <= err_i | (err_q & ~clr_err);
      int_q <= int_i | (int_q & ~clr_int);
      if (we_i[OFF_TIM]) tim_q <= wbyte_i[OFF_TIM];
    end
  end

  for (genvar b = 0; b < DESC_BYTES; b++) begin : g_desc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                desc_q[b] <= '0;
      else if (we_i[OFF_ADR + b]) desc_q[b] <= wbyte_i[OFF_ADR + b];
    end
  end

  always_comb begin
    rbyte_o = '0;
    rbyte_o[OFF_CMD][CMD_START]            = start_q;
    rbyte_o[OFF_CMD][CMD_DIR]              = dir_q;
    rbyte_o[OFF_MODE]                      = mode_i;
    rbyte_o[OFF_STAT][ST_ACT]              = active_i;
    rbyte_o[OFF_STAT][ST_ERR]              = err_q;
    rbyte_o[OFF_STAT][ST_INT]              = int_q;
    rbyte_o[OFF_STAT][ST_KEEP_LSB +: 2]    = keep_q;
    rbyte_o[OFF_TIM]                       = tim_q;
    for (int b = 0; b < DESC_BYTES; b++) rbyte_o[OFF_ADR + b] = desc_q[b];
  end

  assign start_o  = start_q;
  assign dir_o    = dir_q;
  assign timing_o = tim_q;
  assign desc_o   = desc_q;

  logic unused_wbits;
  assign unused_wbits = ^{wbyte_i[OFF_MODE], we_i[OFF_MODE], cmd_w[7:4], cmd_w[2:1],
                          st_w[7], st_w[4:3], st_w[0]};

  // R8
  err_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err && !err_i) |=> !err_q);
  // R8
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_q);
  // R8
  int_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_int && !int_i) |=> !int_q);
  // R7
  keep_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i[OFF_STAT] |=> (keep_q == $past(st_w[ST_KEEP_LSB +: 2])));
  // R9
  tim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i[OFF_TIM] |=> $stable(tim_q));
endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  host_addr_i,
  input  logic [1:0]  host_size_i,
  input  logic        host_wr_i,
  input  logic [31:0] host_wdata_i,
  output logic [31:0] host_rdata_o,
  input  logic [1:0]  chan_irq_i,
  input  logic [1:0]  eng_active_i,
  input  logic [1:0]  eng_err_i,
  input  logic [1:0]  eng_int_i,
  output logic [1:0]  dma_start_o,
  output logic [1:0]  dma_dir_o,
  output logic [15:0] timing_o,
  output logic [63:0] desc_addr_o,
  output logic        irq_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [WIN_BYTES-1:0]                     we_all;
  logic [WIN_BYTES-1:0][7:0]                wbyte_all;
  logic [WIN_BYTES-1:0][7:0]                rd_all;
  logic [LANES-1:0]                         lane_ok;
  logic [LANES-1:0][WIN_AW-1:0]             lane_off;
  logic [NUM_CH-1:0][GRP_BYTES-1:0][7:0]    ch_rbyte;
  logic [7:0]                               mode_q, mode_wdata;
  logic                                     mode_we;

  ide_bm_decode i_decode (
    .addr_i     (host_addr_i),
    .size_i     (host_size_i),
    .wr_i       (host_wr_i),
    .wdata_i    (host_wdata_i),
    .we_o       (we_all),
    .wbyte_o    (wbyte_all),
    .lane_ok_o  (lane_ok),
    .lane_off_o (lane_off)
  );

  // shared mode byte: either group's offset writes it
  assign mode_we    = we_all[OFF_MODE] | we_all[GRP_BYTES + OFF_MODE];
  assign mode_wdata = we_all[OFF_MODE] ? wbyte_all[OFF_MODE] : wbyte_all[GRP_BYTES + OFF_MODE];

  ide_bm_mode i_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we),
    .wdata_i (mode_wdata),
    .req_i   (chan_irq_i),
    .mode_o  (mode_q),
    .irq_o   (irq_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ide_bm_chan i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (we_all[c*GRP_BYTES +: GRP_BYTES]),
      .wbyte_i  (wbyte_all[c*GRP_BYTES +: GRP_BYTES]),
      .mode_i   (mode_q),
      .active_i (eng_active_i[c]),
      .err_i    (eng_err_i[c]),
      .int_i    (eng_int_i[c]),
      .rbyte_o  (ch_rbyte[c]),
      .start_o  (dma_start_o[c]),
      .dir_o    (dma_dir_o[c]),
      .timing_o (timing_o[c*8 +: 8]),
      .desc_o   (desc_addr_o[c*DESC_BYTES*8 +: DESC_BYTES*8])
    );
    assign rd_all[c*GRP_BYTES +: GRP_BYTES] = ch_rbyte[c];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_rd
    assign host_rdata_o[j*8 +: 8] = lane_ok[j] ? rd_all[lane_off[j]] : 8'hFF;
  end

  // R3
  mode_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_all[OFF_MODE] == rd_all[GRP_BYTES + OFF_MODE]);
  // R12
  rsvd_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_size_i == SZ_RSVD) |-> (host_rdata_o == 32'hFFFF_FFFF));
endmodule

// File: tb/test_ide_bm_regs.sv
module test_ide_bm_regs;
  timeunit 1ns; timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  host_addr_i = '0;
  logic [1:0]  host_size_i = '0;
  logic        host_wr_i = 1'b0;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o;
  logic [1:0]  chan_irq_i = '0, eng_active_i = '0, eng_err_i = '0, eng_int_i = '0;
  logic [1:0]  dma_start_o, dma_dir_o;
  logic [15:0] timing_o;
  logic [63:0] desc_addr_o;
  logic        irq_o;

  always #2 clk_i = ~clk_i;

  ide_bm_regs i_ide_bm_regs (.*);

  int  n_vec = 0, n_bad = 0;
  bit  done = 1'b0;

  // reference model
  logic [1:0]  m_start, m_dir, m_err, m_int, m_blk, m_pend;
  logic [1:0]  m_keep [2];
  logic [7:0]  m_tim  [2];
  logic [31:0] m_adr  [2];

  task automatic model_reset();
    m_start = '0; m_dir = '0; m_err = '0; m_int = '0; m_blk = '0; m_pend = '0;
    for (int c = 0; c < 2; c++) begin m_keep[c] = '0; m_tim[c] = '0; m_adr[c] = '0; end
  endtask

  function automatic int size_mask(logic [1:0] s);
    case (s) 2'd0: return 0; 2'd1: return 1; 2'd2: return 3; default: return -1; endcase
  endfunction

  function automatic logic [7:0] exp_byte(int off);
    int c = off / 8;
    int o = off % 8;
    case (o)
      0: return {4'b0, m_dir[c], 2'b0, m_start[c]};
      1: return {2'b0, m_blk, m_pend, 2'b0};
      2: return {1'b0, m_keep[c], 2'b0, m_int[c], m_err[c], eng_active_i[c]};
      3: return m_tim[c];
      default: return m_adr[c][8*(o-4) +: 8];
    endcase
  endfunction

  function automatic logic [31:0] exp_rdata(logic [3:0] a, logic [1:0] s);
    logic [31:0] r = '1;
    int m = size_mask(s);
    if (m < 0) return r;
    for (int j = 0; j < 4; j++)
      if (j <= m) r[8*j +: 8] = exp_byte(int'(a & ~4'(m)) + j);
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] a, logic [1:0] s);
    if (s == 2'd3) return "R12";
    case (a[2:0])
      3'd0: return "R11";
      3'd1: return "R4";
      3'd2: return "R7";
      3'd3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model_write(logic [3:0] a, logic [1:0] s, logic wr, logic [31:0] wd);
    logic [1:0] clr_e = '0, clr_i = '0;
    int m = size_mask(s);
    if (wr && m >= 0) begin
      for (int off = 0; off < 16; off++) begin
        if ((off & ~m) == int'(a & ~4'(m))) begin
          int c = off / 8;
          int o = off % 8;
          logic [7:0] b = wd[8*(off & m) +: 8];
          case (o)
            0: begin m_start[c] = b[0]; m_dir[c] = b[3]; end
            1: m_blk = b[5:4];
            2: begin m_keep[c] = b[6:5]; clr_e[c] = b[1]; clr_i[c] = b[2]; end
            3: m_tim[c] = b;
            default: m_adr[c][8*(o-4) +: 8] = b;
          endcase
        end
      end
    end
    m_err  = eng_err_i | (m_err & ~clr_e);
    m_int  = eng_int_i | (m_int & ~clr_i);
    m_pend = chan_irq_i;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [3:0] a, logic [1:0] s, logic wr, logic [31:0] wd,
                      logic [1:0] irq, logic [1:0] act, logic [1:0] er, logic [1:0] it);
    host_addr_i = a; host_size_i = s; host_wr_i = wr; host_wdata_i = wd;
    chan_irq_i = irq; eng_active_i = act; eng_err_i = er; eng_int_i = it;
    #1;
    check((tag == "") ? tag_of(a, s) : tag, host_rdata_o, exp_rdata(a, s));
    check((tag == "") ? "R6" : tag, {31'b0, irq_o}, {31'b0, |(m_pend & ~m_blk)});
    model_write(a, s, wr, wd);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd7741);
    model_reset();
    repeat (4) @(negedge clk_i);
    // R1: reset state of outputs
    check("R1", {31'b0, irq_o}, 32'd0);
    check("R1", {dma_start_o, dma_dir_o, timing_o}, 20'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: all registers zero, status bit0 follows engine active
    step("R1", 4'd0,  2'd2, 0, 0, 2'b00, 2'b01, 0, 0);
    step("R1", 4'd8,  2'd2, 0, 0, 2'b00, 2'b10, 0, 0);
    step("R1", 4'd4,  2'd2, 0, 0, 2'b00, 2'b00, 0, 0);
    step("R1", 4'd12, 2'd2, 0, 0, 2'b00, 2'b00, 0, 0);
    // R2 / R10: pointer placement per channel and access size
    step("R10", 4'd4,  2'd2, 1, 32'h1122_3344, 0, 0, 0, 0);
    step("R10", 4'd12, 2'd2, 1, 32'h5566_7788, 0, 0, 0, 0);
    step("R2",  4'd4,  2'd2, 0, 0, 0, 0, 0, 0);
    step("R2",  4'd12, 2'd2, 0, 0, 0, 0, 0, 0);
    step("R10", 4'd7,  2'd1, 1, 32'hFFFF_BEEF, 0, 0, 0, 0); // aligned down to 6
    step("R10", 4'd7,  2'd0, 0, 0, 0, 0, 0, 0);
    step("R10", 4'd5,  2'd2, 0, 0, 0, 0, 0, 0);
    step("R10", 4'd13, 2'd0, 1, 32'h0000_00A1, 0, 0, 0, 0);
    step("R10", 4'd12, 2'd1, 0, 0, 0, 0, 0, 0);
    if (desc_addr_o !== 64'h5566_A188_BEEF_3344) begin
      n_bad++;
      $display("FAIL R10: actual=%h expected=%h", desc_addr_o, 64'h5566_A188_BEEF_3344);
    end
    n_vec++;
    // R11: command masking
    step("R11", 4'd0, 2'd0, 1, 32'h0000_00FF, 0, 0, 0, 0);
    step("R11", 4'd0, 2'd0, 0, 0, 0, 0, 0, 0);
    step("R11", 4'd8, 2'd0, 1, 32'h0000_0008, 0, 0, 0, 0);
    step("R11", 4'd8, 2'd0, 0, 0, 0, 0, 0, 0);
    check("R11", {28'b0, dma_start_o, dma_dir_o}, {28'b0, 2'b01, 2'b11});
    // R9: separate timing bytes
    step("R9", 4'd3,  2'd0, 1, 32'h0000_00A5, 0, 0, 0, 0);
    step("R9", 4'd11, 2'd0, 1, 32'h0000_003C, 0, 0, 0, 0);
    step("R9", 4'd3,  2'd0, 0, 0, 0, 0, 0, 0);
    step("R9", 4'd11, 2'd0, 0, 0, 0, 0, 0, 0);
    // R5 / R3 / R6: pending follows request, shared view
    step("R5", 4'd1, 2'd0, 0, 0, 2'b10, 0, 0, 0);
    step("R3", 4'd1, 2'd0, 0, 0, 2'b10, 0, 0, 0);
    step("R3", 4'd9, 2'd0, 0, 0, 2'b11, 0, 0, 0);
    step("R6", 4'd9, 2'd0, 0, 0, 2'b11, 0, 0, 0);
    // R4: block both, then unblock channel 1 only
    step("R4", 4'd9, 2'd0, 1, 32'h0000_00FF, 2'b11, 0, 0, 0);
    step("R6", 4'd1, 2'd0, 0, 0, 2'b11, 0, 0, 0);
    step("R4", 4'd1, 2'd0, 1, 32'h0000_0010, 2'b11, 0, 0, 0);
    step("R6", 4'd1, 2'd0, 0, 0, 2'b01, 0, 0, 0);
    step("R6", 4'd9, 2'd0, 0, 0, 2'b00, 0, 0, 0);
    step("R6", 4'd9, 2'd0, 0, 0, 2'b00, 0, 0, 0);
    // R8: strobe set, clear lost to strobe, clear
    step("R8", 4'd2, 2'd0, 0, 0, 0, 2'b01, 2'b01, 2'b10);
    step("R8", 4'd2, 2'd0, 1, 32'h0000_0006, 0, 2'b01, 2'b01, 0);
    step("R8", 4'd2, 2'd0, 1, 32'h0000_0000, 0, 2'b01, 0, 0);
    step("R8", 4'd2, 2'd0, 1, 32'h0000_0006, 0, 2'b01, 0, 0);
    step("R8", 4'd10, 2'd0, 1, 32'h0000_0004, 0, 2'b10, 0, 0);
    step("R8", 4'd10, 2'd0, 0, 0, 0, 2'b10, 0, 0);
    // R7: writable and fixed status bits
    step("R7", 4'd2, 2'd0, 1, 32'h0000_00F9, 0, 2'b00, 0, 0);
    step("R7", 4'd2, 2'd0, 0, 0, 0, 2'b01, 0, 0);
    // R12: reserved size and unused lanes
    step("R12", 4'd0, 2'd3, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step("R12", 4'd0, 2'd2, 0, 0, 0, 0, 0, 0);
    step("R12", 4'd3, 2'd0, 0, 0, 0, 0, 0, 0);
    step("R12", 4'd14, 2'd1, 0, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      step("", 4'($urandom % 16), 2'($urandom % 4), 1'($urandom % 2), $urandom,
           2'($urandom % 4), 2'($urandom % 4),
           {($urandom % 8) == 0, ($urandom % 8) == 0},
           {($urandom % 8) == 0, ($urandom % 8) == 0});
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule